// File: doc/BRIEF.md
# Triggered three-slot pattern generator

The block is a small synchronous state machine that turns a level request into a single, fixed-length burst on one output line. While it idles, its output stays low. When the request input is seen high on a clock edge, the block plays a three-clock pattern, one clock per slot. The first slot is high and the second is low. The third slot copies a select input, so the line shows either 1-0-1 or 1-0-0.

After the third slot the block parks in a hold state and keeps its output low. It will not run again until the request has been seen low. One assertion of the request therefore yields exactly one pattern, however long the request stays high. Once a pattern has begun it always runs to the end, whatever the request does.

The output is a registered-state decode and carries no clock term. In the third slot only, it also depends combinationally on the select input. All pins are plain control signals with no handshake, since no data stream passes through the block.

Top module: `trig_burst_gen`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the machine goes to idle whatever `req_i` does. `pat_o` is 0 in the cycle after any such edge.
- R2: In idle, `pat_o` is 0. The machine stays idle for as long as `req_i` is sampled low.
- R3: If `req_i` is sampled high in idle, `pat_o` is 1 for the next clock cycle. This is the first slot.
- R4: The first slot lasts one clock and is followed by the second slot. The second slot lasts one clock with `pat_o` = 0 and is followed by the third slot.
- R5: The third slot lasts one clock. During it, `pat_o` equals the present value of `sel_last_i`, so a high select gives the pattern 101 and a low select gives 100.
- R6: The value of `req_i` during any of the three slots has no effect. The pattern always completes.
- R7: After the third slot the machine enters the hold state, where `pat_o` is 0. It stays there while `req_i` is sampled high, so a request held high never repeats the pattern.
- R8: If `req_i` is sampled low in the hold state, the machine returns to idle on that edge. A later high sample in idle starts a new pattern, as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request level; a high sample in idle starts one pattern |
| sel_last_i | input | 1 | Value driven in the third slot (1 gives 101, 0 gives 100) |
| pat_o | output | 1 | Pattern output |

## Verification
A wrong state shows at `pat_o` within one to three cycles. A slot that is skipped or held for an extra cycle moves the second high pulse or doubles a level. A hold state that does not wait for the request to drop shows a repeated 1 pulse about four cycles after the first one, even though the request never went low. A missed return to idle shows as no pulse one cycle after the request rises again.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SLOT_A = 3'd1,
    ST_SLOT_B = 3'd2,
    ST_SLOT_C = 3'd3,
    ST_HOLD   = 3'd4
  } tbg_state_e;
endpackage

// File: rtl/tbg_next.sv
module tbg_next
  import tbg_pkg::*;
(
  input  tbg_state_e st_i,
  input  logic       req_i,
  output tbg_state_e st_nxt_o
);
  always_comb begin
    case (st_i)
      ST_IDLE:   st_nxt_o = req_i ? ST_SLOT_A : ST_IDLE;
      ST_SLOT_A: st_nxt_o = ST_SLOT_B;
      ST_SLOT_B: st_nxt_o = ST_SLOT_C;
      ST_SLOT_C: st_nxt_o = ST_HOLD;
      ST_HOLD:   st_nxt_o = req_i ? ST_HOLD : ST_IDLE;
      default:   st_nxt_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/tbg_out.sv
module tbg_out
  import tbg_pkg::*;
(
  input  tbg_state_e st_i,
  input  logic       sel_last_i,
  output logic       pat_o
);
  always_comb begin
    case (st_i)
      ST_SLOT_A: pat_o = 1'b1;
      ST_SLOT_C: pat_o = sel_last_i;
      default:   pat_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen
  import tbg_pkg::*;
(
  input  logic clk,
  input  logic rst_i,
  input  logic req_i,
  input  logic sel_last_i,
  output logic pat_o
);
  tbg_state_e st_q;
  tbg_state_e st_d;

  tbg_next u_next (
    .st_i     (st_q),
    .req_i    (req_i),
    .st_nxt_o (st_d)
  );

  tbg_out u_out (
    .st_i       (st_q),
    .sel_last_i (sel_last_i),
    .pat_o      (pat_o)
  );

  always_ff @(posedge clk) begin
    if (rst_i) st_q <= ST_IDLE;
    else       st_q <= st_d;
  end

  // R2: a quiet idle stays quiet
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == ST_IDLE && !req_i) |=> !pat_o);

  // R3: a request in idle opens with a high slot
  a_r3_start_high: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == ST_IDLE && req_i) |=> pat_o);

  // R4: slots follow one per clock
  a_r4_chain_ab: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == ST_SLOT_A) |=> (st_q == ST_SLOT_B));
  a_r4_chain_bc: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == ST_SLOT_B) |=> (st_q == ST_SLOT_C));

  // R4: no two adjacent high cycles ever appear
  a_r4_no_adjacent_high: assert property (@(posedge clk) disable iff (rst_i)
    pat_o |=> !pat_o);

  // R7: third slot hands over to hold; held request keeps it there
  a_r7_enter_hold: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == ST_SLOT_C) |=> (st_q == ST_HOLD));
  a_r7_no_repeat: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == ST_HOLD && req_i) |=> (st_q == ST_HOLD && !pat_o));

  // R8: a low request releases hold
  a_r8_release: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == ST_HOLD && !req_i) |=> (st_q == ST_IDLE));
endmodule

// File: tb/sim_trig_burst_gen.sv
`timescale 1ns/1ps
module sim_trig_burst_gen;
  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic req_i = 1'b0;
  logic sel_last_i = 1'b0;
  logic pat_o;

  int n_checks = 0;
  int n_errors = 0;
  int ph = 0; // 0 idle, 1..3 slots, 4 hold

  always #5 clk = ~clk;

  trig_burst_gen u0 (
    .clk        (clk),
    .rst_i      (rst_i),
    .req_i      (req_i),
    .sel_last_i (sel_last_i),
    .pat_o      (pat_o)
  );

  function automatic logic exp_pat(input int p, input logic sel);
    if (p == 1) return 1'b1;
    if (p == 3) return sel;
    return 1'b0;
  endfunction

  function automatic int next_ph(input int p, input logic rst, input logic req);
    if (rst) return 0;
    case (p)
      0: return req ? 1 : 0;
      1: return 2;
      2: return 3;
      3: return 4;
      default: return req ? 4 : 0;
    endcase
  endfunction

  function automatic string ph_tag(input int p);
    case (p)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic r, input logic q, input logic sel, input string ov);
    string tag;
    logic e;
    @(negedge clk);
    tag = (ov == "") ? ph_tag(ph) : ov;
    e = exp_pat(ph, sel_last_i);
    n_checks++;
    if (pat_o !== e) begin
      n_errors++;
      $display("FAIL %s: pat_o=%b expected %b (phase %0d)", tag, pat_o, e, ph);
    end
    rst_i = r;
    req_i = q;
    sel_last_i = sel;
    @(posedge clk);
    ph = next_ph(ph, rst_i, req_i);
  endtask

  initial begin
    #(200_000 * 10);
    n_errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_i = 1'b1;
    req_i = 1'b1;
    @(posedge clk);
    @(posedge clk);
    ph = 0;
    // R1: reset dominates a high request
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b1, "R1");
    // R2: idle with request low
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, "");
    // R3..R5 pattern 101, request dropped during slots (R6)
    step(1'b0, 1'b1, 1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b1, "R6");
    // now in hold with request low: it must release (R8)
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    // R5: pattern 100 with request held high throughout
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "");
    // R7: hold while request stays high
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    // R1: reset in the middle of a pattern
    step(1'b1, 1'b1, 1'b1, "");
    step(1'b0, 1'b0, 1'b1, "R1");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic rr, qq, ss;
      rr = ($urandom_range(0, 63) == 0);
      qq = ($urandom_range(0, 3) != 0) ? ~req_i : req_i;
      if ($urandom_range(0, 1) == 1) qq = req_i;
      ss = $urandom_range(0, 1) == 1;
      step(rr, qq, ss, "");
    end
    step(1'b0, 1'b0, 1'b0, "");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule